// File: doc/BRIEF.md
# Write-Channel Transaction Order and Burst Length Monitor

This block watches one master-side AXI write interface without touching it. It follows the address, data and response handshakes and reports two kinds of fault. The first is a write response that arrives for an ID with no outstanding request. The second is a data burst whose beat count does not match the length announced with its address. A small table keyed by ID counts the outstanding writes for each ID. A queue of announced lengths, kept in address order, checks each burst against the beats that actually arrive.

Faults set sticky flag bits, which stay set until the clear input is raised. The first fault after reset or after a clear is recorded with its ID, a 2-bit code and the value of a free-running cycle counter. That record is offered to a trace collector with a single-cycle valid pulse.

The monitor assumes that each write address is accepted in an earlier cycle than the first data beat of its burst. It also assumes that no ID has more than 255 writes outstanding.

Top module: `wr_order_mon`

## Requirements
- R1: After reset, `err_flags` is 0 and `trc_valid` is 0.
- R2: A response handshake whose ID has no outstanding write sets `err_flags[0]` (order fault, code 0).
- R3: Writes with the same ID are counted. Each response for that ID retires one of them. A response beyond the number issued for that ID is an order fault.
- R4: A beat with `w_last` high that ends a burst with fewer beats than length+1 sets `err_flags[1]` (short burst, code 1). The recorded ID is the ID of that burst.
- R5: A beat that reaches or passes length+1 beats without `w_last` sets `err_flags[2]` (overrun, code 2), with the ID of that burst. A beat that arrives when no burst is pending is also an overrun, recorded with ID 0.
- R6: Bursts with exactly length+1 beats, ending in `w_last`, followed by their matching responses, raise no flag.
- R7: An address handshake that arrives when all DEPTH table entries hold other IDs, or when DEPTH bursts are pending, sets `err_flags[3]` (table full, code 3) and is not tracked. A later response for that ID is an order fault.
- R8: Flags stay set until `clr` is high at a clock edge. That edge clears every flag and re-arms the record. A fault in the same cycle as `clr` is discarded.
- R9: The first fault after reset or a clear drives `trc_valid` high for exactly one cycle, starting the cycle after the faulting edge. From that cycle the trace outputs hold the fault's ID and code, and later faults do not change them until the next clear.
- R10: `trc_stamp` is the number of clock edges seen since reset was released before the faulting edge.
- R11: When several faults occur at one edge, all of their flags are set and the record keeps the fault with the lowest code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Clears the flags and re-arms the record |
| aw_valid | input | 1 | Write address valid (observed) |
| aw_ready | input | 1 | Write address ready (observed) |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | LEN_W | Announced beats minus one |
| w_valid | input | 1 | Write data valid (observed) |
| w_ready | input | 1 | Write data ready (observed) |
| w_last | input | 1 | Final beat marker |
| b_valid | input | 1 | Write response valid (observed) |
| b_ready | input | 1 | Write response ready (observed) |
| b_id | input | ID_W | Write response ID |
| err_flags | output | 4 | Sticky flags: bit0 order, bit1 short, bit2 overrun, bit3 full |
| trc_valid | output | 1 | One-cycle pulse when a record is captured |
| trc_id | output | ID_W | Recorded ID |
| trc_code | output | 2 | Recorded code: 0 order, 1 short, 2 overrun, 3 full |
| trc_stamp | output | STAMP_W | Recorded cycle stamp |

## Verification
Directed sequences each isolate one fault class: a response to an idle ID, repeated same-ID writes with one response too many, early and late `w_last`, data with no pending burst, and a request that overflows the table. Together they show that each class lands on its own flag and record code. Further directed cases put an order fault and a short burst on the same edge, and put a fault on the same edge as a clear. These separate the capture priority from the clear priority. A seeded random run mixes correct bursts with short and overrun bursts of random length and ID. It shows that the beat count is measured per burst and is not confused by neighbouring traffic.

// File: rtl/wom_pkg.sv
// Shared definitions for the write-channel order monitor.
package wom_pkg;
    localparam int NUM_ERR = 4;
    typedef enum logic [1:0] {
        ERR_ORDER = 2'd0,
        ERR_SHORT = 2'd1,
        ERR_OVER  = 2'd2,
        ERR_FULL  = 2'd3
    } err_code_e;
endpackage

// File: rtl/wom_id_table.sv
// Outstanding-write table keyed by ID. Each entry holds a valid bit, an ID
// and the number of writes outstanding for it. A lookup on the request ID
// decides whether a new entry is needed; a response retires one write.
// Assumes DEPTH >= 2 and fewer than 2**CNT_W writes outstanding per ID.
module wom_id_table #(
    parameter int ID_W  = 4,
    parameter int DEPTH = 8,
    parameter int CNT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_chk,
    input  logic [ID_W-1:0] req_id,
    input  logic            req_push,
    input  logic            rsp_valid,
    input  logic [ID_W-1:0] rsp_id,
    output logic            tbl_full,
    output logic            rsp_bad
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0] vld_q;
    logic [ID_W-1:0]  id_q  [DEPTH];
    logic [CNT_W-1:0] cnt_q [DEPTH];

    logic             req_hit, rsp_hit, free_ok, same_dec;
    logic [IDX_W-1:0] req_idx, rsp_idx, free_idx;

    // Search the table for the request ID, the response ID and a free slot.
    always_comb begin
        req_hit  = 1'b0; req_idx  = '0;
        rsp_hit  = 1'b0; rsp_idx  = '0;
        free_ok  = 1'b0; free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld_q[i] && id_q[i] == req_id) begin
                req_hit = 1'b1; req_idx = IDX_W'(i);
            end
            if (vld_q[i] && id_q[i] == rsp_id) begin
                rsp_hit = 1'b1; rsp_idx = IDX_W'(i);
            end
            if (!vld_q[i]) begin
                free_ok = 1'b1; free_idx = IDX_W'(i);
            end
        end
    end

    assign tbl_full = req_chk && !req_hit && !free_ok;
    assign rsp_bad  = rsp_valid && !rsp_hit;
    assign same_dec = rsp_valid && rsp_hit && (rsp_idx == req_idx);

    // Update entry counts: retire on a response, add or allocate on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                id_q[i]  <= '0;
                cnt_q[i] <= '0;
            end
        end else begin
            if (rsp_valid && rsp_hit) begin
                cnt_q[rsp_idx] <= cnt_q[rsp_idx] - 1'b1;
                if (cnt_q[rsp_idx] == CNT_W'(1)) vld_q[rsp_idx] <= 1'b0;
            end
            if (req_push && req_hit) begin
                vld_q[req_idx] <= 1'b1;
                cnt_q[req_idx] <= same_dec ? cnt_q[req_idx] : cnt_q[req_idx] + 1'b1;
            end else if (req_push) begin
                vld_q[free_idx] <= 1'b1;
                id_q[free_idx]  <= req_id;
                cnt_q[free_idx] <= CNT_W'(1);
            end
        end
    end

    // Table invariants: a live entry has writes outstanding, and IDs are unique.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                // R3
                live_cnt_chk: assert (!vld_q[i] || cnt_q[i] != '0)
                    else $error("valid entry with zero count");
                for (int j = i + 1; j < DEPTH; j++) begin
                    // R3
                    uniq_id_chk: assert (!(vld_q[i] && vld_q[j] && id_q[i] == id_q[j]))
                        else $error("duplicate ID in table");
                end
            end
        end
    end
endmodule

// File: rtl/wom_beat_check.sv
// Queue of announced burst lengths in address order, and a beat counter for
// the burst at its head. Flags early and late end-of-burst markers.
// Assumes DEPTH is a power of two and that each address is accepted in an
// earlier cycle than the first data beat of its burst.
module wom_beat_check #(
    parameter int ID_W  = 4,
    parameter int LEN_W = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ID_W-1:0]  push_id,
    input  logic [LEN_W-1:0] push_len,
    input  logic             beat,
    input  logic             last,
    output logic             q_full,
    output logic             short_err,
    output logic             over_err,
    output logic [ID_W-1:0]  err_id
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [ID_W-1:0]  id_mem  [DEPTH];
    logic [LEN_W-1:0] len_mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [PTR_W:0]   cnt_q;
    logic [LEN_W:0]   beats_q, beat_no;
    logic             empty, pop;

    assign empty   = (cnt_q == '0);
    assign q_full  = (cnt_q == (PTR_W+1)'(DEPTH));
    assign beat_no = beats_q + 1'b1;
    assign pop     = beat && last && !empty;

    // Classify the current beat against the length at the head of the queue.
    always_comb begin
        short_err = 1'b0;
        over_err  = 1'b0;
        err_id    = empty ? '0 : id_mem[rd_q];
        if (beat && empty)
            over_err = 1'b1;
        else if (beat && last)
            short_err = (beat_no <= {1'b0, len_mem[rd_q]});
        else if (beat)
            over_err = (beat_no > {1'b0, len_mem[rd_q]});
    end

    // Advance the length queue and the beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0; rd_q <= '0; cnt_q <= '0; beats_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                id_mem[i]  <= '0;
                len_mem[i] <= '0;
            end
        end else begin
            if (push) begin
                id_mem[wr_q]  <= push_id;
                len_mem[wr_q] <= push_len;
                wr_q          <= wr_q + 1'b1;
            end
            if (pop) rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
            if (beat && last)
                beats_q <= '0;
            else if (beat && !empty && beats_q != '1)
                beats_q <= beat_no;
        end
    end

    // R7
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !push);
    // R5
    beats_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last) |=> (beats_q == '0));
endmodule

// File: rtl/wom_err_capture.sv
// Sticky fault flags, a free-running cycle counter, and the first-fault
// record with its one-cycle trace pulse. The lowest code wins when several
// faults share an edge; a clear wins over any fault in its own cycle.
module wom_err_capture
    import wom_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int STAMP_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic [NUM_ERR-1:0]             err,
    input  logic [NUM_ERR-1:0][ID_W-1:0]   err_ids,
    output logic [NUM_ERR-1:0]             flags,
    output logic                           trc_valid,
    output logic [ID_W-1:0]                trc_id,
    output logic [1:0]                     trc_code,
    output logic [STAMP_W-1:0]             trc_stamp
);
    logic [STAMP_W-1:0] stamp_q;
    logic               held_q;
    logic [1:0]         pick;

    // Select the lowest-numbered fault present this cycle.
    always_comb begin
        pick = 2'd0;
        for (int k = NUM_ERR - 1; k >= 0; k--)
            if (err[k]) pick = 2'(k);
    end

    // Free-running stamp counter.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp_q <= '0;
        else        stamp_q <= stamp_q + 1'b1;
    end

    // Sticky flags and first-fault record.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags     <= '0;
            held_q    <= 1'b0;
            trc_valid <= 1'b0;
            if (!rst_n) begin
                trc_id    <= '0;
                trc_code  <= '0;
                trc_stamp <= '0;
            end
        end else begin
            flags     <= flags | err;
            trc_valid <= 1'b0;
            if (!held_q && err != '0) begin
                held_q    <= 1'b1;
                trc_valid <= 1'b1;
                trc_id    <= err_ids[pick];
                trc_code  <= pick;
                trc_stamp <= stamp_q;
            end
        end
    end

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));
    // R8
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == '0 && !trc_valid));
    // R9
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trc_valid |=> !trc_valid);
    // R9
    record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_valid && !clr) |=> ($stable(trc_id) && $stable(trc_code) && $stable(trc_stamp)));
endmodule

// File: rtl/wr_order_mon.sv
// Top of the passive write-channel monitor. Turns bus handshakes into
// table, queue and capture events; drives nothing onto the bus.
module wr_order_mon
    import wom_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int LEN_W   = 8,
    parameter int DEPTH   = 8,
    parameter int STAMP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               aw_valid,
    input  logic               aw_ready,
    input  logic [ID_W-1:0]    aw_id,
    input  logic [LEN_W-1:0]   aw_len,
    input  logic               w_valid,
    input  logic               w_ready,
    input  logic               w_last,
    input  logic               b_valid,
    input  logic               b_ready,
    input  logic [ID_W-1:0]    b_id,
    output logic [3:0]         err_flags,
    output logic               trc_valid,
    output logic [ID_W-1:0]    trc_id,
    output logic [1:0]         trc_code,
    output logic [STAMP_W-1:0] trc_stamp
);
    localparam int CNT_W = 8;

    logic aw_hs, w_hs, b_hs;
    logic tbl_full, q_full, accept, rsp_bad, short_err, over_err;
    logic [ID_W-1:0]                 beat_id;
    logic [NUM_ERR-1:0]              err_vec;
    logic [NUM_ERR-1:0][ID_W-1:0]    err_ids;

    assign aw_hs  = aw_valid && aw_ready;
    assign w_hs   = w_valid && w_ready;
    assign b_hs   = b_valid && b_ready;
    assign accept = aw_hs && !tbl_full && !q_full;

    assign err_vec = {aw_hs && (tbl_full || q_full), over_err, short_err, rsp_bad};
    assign err_ids = {aw_id, beat_id, beat_id, b_id};

    wom_id_table #(.ID_W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .req_chk(aw_hs), .req_id(aw_id), .req_push(accept),
        .rsp_valid(b_hs), .rsp_id(b_id),
        .tbl_full(tbl_full), .rsp_bad(rsp_bad)
    );

    wom_beat_check #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_beats (
        .clk(clk), .rst_n(rst_n),
        .push(accept), .push_id(aw_id), .push_len(aw_len),
        .beat(w_hs), .last(w_last),
        .q_full(q_full), .short_err(short_err), .over_err(over_err), .err_id(beat_id)
    );

    wom_err_capture #(.ID_W(ID_W), .STAMP_W(STAMP_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .err(err_vec), .err_ids(err_ids),
        .flags(err_flags), .trc_valid(trc_valid), .trc_id(trc_id),
        .trc_code(trc_code), .trc_stamp(trc_stamp)
    );

    // R2
    order_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_hs && rsp_bad && !clr) |=> err_flags[0]);
    // R11
    first_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trc_valid |-> err_flags[trc_code]);
endmodule

// File: tb/wr_order_mon_test.sv
module wr_order_mon_test;
    logic        clk = 1'b0;
    logic        rst_n, clr;
    logic        aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
    logic [3:0]  aw_id, b_id;
    logic [7:0]  aw_len;
    logic [3:0]  err_flags;
    logic        trc_valid;
    logic [3:0]  trc_id;
    logic [1:0]  trc_code;
    logic [15:0] trc_stamp;

    int total = 0, bad = 0, bcyc = 0;
    int stamp_exp = 0;

    always #5 clk = ~clk;

    wr_order_mon uut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
        .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
        .err_flags(err_flags), .trc_valid(trc_valid), .trc_id(trc_id),
        .trc_code(trc_code), .trc_stamp(trc_stamp)
    );

    // Edges since reset release, as the stamp is defined in R10.
    always @(posedge clk) begin
        if (!rst_n) bcyc <= 0;
        else        bcyc <= bcyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus; returns at the following falling edge.
    task automatic step(input bit aw, input int awid, input int awlen,
                        input bit w, input bit wl, input bit b, input int bid,
                        input bit c);
        aw_valid = aw; aw_ready = aw; aw_id = 4'(awid); aw_len = 8'(awlen);
        w_valid = w; w_ready = w; w_last = wl;
        b_valid = b; b_ready = b; b_id = 4'(bid);
        clr = c;
        stamp_exp = bcyc;
        @(posedge clk);
        @(negedge clk);
        aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0;
        b_valid = 0; b_ready = 0; clr = 0;
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic clear(); step(0, 0, 0, 0, 0, 0, 0, 1); endtask

    task automatic do_reset();
        rst_n = 0;
        idle(); idle();
        rst_n = 1;
    endtask

    function automatic int exp_flags(input int kind);
        case (kind)
            1: return 2;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int st;
        void'($urandom(32'd4242));
        aw_valid = 0; aw_ready = 0; w_valid = 0; w_ready = 0; w_last = 0;
        b_valid = 0; b_ready = 0; aw_id = 0; b_id = 0; aw_len = 0; clr = 0;
        rst_n = 0;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 flags", int'(err_flags), 0);
        chk("R1 trc_valid", int'(trc_valid), 0);

        // R6 exact burst id3 len3
        step(1, 3, 3, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1, i == 3, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 3, 0);
        chk("R6 exact burst", int'(err_flags), 0);

        // R2 response to idle ID 5, R9/R10 record
        idle(); idle();
        step(0, 0, 0, 0, 0, 1, 5, 0);
        st = stamp_exp;
        chk("R2 order flag", int'(err_flags), 1);
        chk("R9 pulse", int'(trc_valid), 1);
        chk("R9 id", int'(trc_id), 5);
        chk("R9 code", int'(trc_code), 0);
        chk("R10 stamp", int'(trc_stamp), st & 16'hffff);
        // R9 pulse lasts one cycle; later fault keeps record
        step(0, 0, 0, 1, 1, 0, 0, 0);
        chk("R9 pulse ends", int'(trc_valid), 0);
        chk("R5 data with no burst", int'(err_flags), 5);
        chk("R9 record held id", int'(trc_id), 5);
        chk("R9 record held code", int'(trc_code), 0);
        idle();
        chk("R8 sticky", int'(err_flags), 5);
        clear();
        chk("R8 cleared", int'(err_flags), 0);

        // R4 short burst id2 len3, two beats
        step(1, 2, 3, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0, 0);
        chk("R4 short flag", int'(err_flags), 2);
        chk("R4 id", int'(trc_id), 2);
        chk("R4 code", int'(trc_code), 1);
        step(0, 0, 0, 0, 0, 1, 2, 0);
        clear();

        // R5 late end marker id1 len1
        step(1, 1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 no early flag", int'(err_flags), 0);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 overrun flag", int'(err_flags), 4);
        chk("R5 id", int'(trc_id), 1);
        chk("R5 code", int'(trc_code), 2);
        step(0, 0, 0, 1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 1, 0);
        clear();
        // R5 beat with empty queue records ID 0
        step(0, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 empty queue flag", int'(err_flags), 4);
        chk("R5 empty queue id", int'(trc_id), 0);
        clear();

        // R3 same-ID counting
        step(1, 4, 0, 0, 0, 0, 0, 0);
        step(1, 4, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 4, 0);
        step(0, 0, 0, 0, 0, 1, 4, 0);
        chk("R3 two responses ok", int'(err_flags), 0);
        step(0, 0, 0, 0, 0, 1, 4, 0);
        chk("R3 third response", int'(err_flags), 1);
        chk("R3 id", int'(trc_id), 4);
        clear();

        // R11 order fault and short burst on one edge
        step(1, 6, 2, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 1, 9, 0);
        chk("R11 both flags", int'(err_flags), 3);
        chk("R11 lowest code", int'(trc_code), 0);
        chk("R11 id", int'(trc_id), 9);
        step(0, 0, 0, 0, 0, 1, 6, 0);
        clear();

        // R8 clear wins over same-cycle fault
        step(0, 0, 0, 0, 0, 1, 12, 1);
        chk("R8 clear wins", int'(err_flags), 0);
        chk("R8 no pulse", int'(trc_valid), 0);

        // R7 table full
        do_reset();
        for (int i = 0; i < 8; i++) step(1, i, 0, 0, 0, 0, 0, 0);
        chk("R7 eight fit", int'(err_flags), 0);
        step(1, 8, 0, 0, 0, 0, 0, 0);
        chk("R7 full flag", int'(err_flags), 8);
        chk("R7 code", int'(trc_code), 3);
        chk("R7 id", int'(trc_id), 8);
        clear();
        step(0, 0, 0, 0, 0, 1, 8, 0);
        chk("R7 untracked", int'(err_flags), 1);

        // Random mix of good, short and overrun bursts
        do_reset();
        for (int n = 0; n < 150; n++) begin
            int kind, len, id, beats, fault_at, fst;
            kind = int'($urandom % 3);
            len  = int'($urandom % 8);
            id   = int'($urandom % 16);
            if (kind == 1 && len == 0) kind = 0;
            case (kind)
                1: beats = 1 + int'($urandom % len);
                2: beats = len + 2 + int'($urandom % 2);
                default: beats = len + 1;
            endcase
            fault_at = (kind == 2) ? len + 1 : beats;
            fst = 0;
            clear();
            step(1, id, len, 0, 0, 0, 0, 0);
            for (int b = 1; b <= beats; b++) begin
                if ($urandom % 4 == 0) idle();
                step(0, 0, 0, 1, b == beats, 0, 0, 0);
                if (b == fault_at) fst = stamp_exp;
            end
            step(0, 0, 0, 0, 0, 1, id, 0);
            chk(kind == 0 ? "R6 random good" : (kind == 1 ? "R4 random short" : "R5 random overrun"),
                int'(err_flags), exp_flags(kind));
            if (kind != 0) begin
                chk("R9 random code", int'(trc_code), kind);
                chk("R9 random id", int'(trc_id), id);
                chk("R10 random stamp", int'(trc_stamp), fst & 16'hffff);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule